// File: doc/BRIEF.md
# DDR2 Activate Timing Guard

This block decides, one clock at a time, whether a candidate command for an eight-bank DDR2 memory may be issued now without breaking any row timing rule. Each cycle a scheduler presents one command (no-op, activate, read, write or precharge) with a bank and a row address. The guard answers with a combinational grant in the same cycle. If the command is a granted non-NOP, it reports the command one cycle later on an issued strobe together with its bank and row.

Internally the guard keeps, for every bank, whether a row is open and how many clocks have passed since that bank's last activate and last precharge. It also keeps one counter for the time since the most recent activate to any bank, and a four-entry history of activate ages for the rolling activate window. Every limit is a whole number of clocks set by a parameter. A limit given in nanoseconds is turned into clocks by dividing by the clock period and rounding up: 20 ns at 3.75 ns gives 6. All counters saturate, so an idle spell of any length leaves them expired. Reset closes every bank and marks every counter as expired.

Top module: `act_timing_guard`

## Requirements
- R1: A READ or WRITE is granted only to a bank that holds an open row.
- R2: A READ or WRITE to a bank is granted only when at least T_RCD clocks have passed since that bank's granted ACTIVATE.
- R3: An ACTIVATE to a bank whose row is open is refused until a PRECHARGE to that bank has been granted.
- R4: Two granted ACTIVATEs to the same bank are at least T_RC clocks apart.
- R5: Any two granted ACTIVATEs, to any banks, are at least T_RRD clocks apart. Other banks may be activated while one bank has an open row.
- R6: At most four ACTIVATEs are granted in any window of T_FAW clocks. A fifth is granted only once the oldest of the last four is at least T_FAW clocks old.
- R7: A PRECHARGE to an in-range bank is always granted and closes that bank. A later ACTIVATE to that bank waits at least T_RP clocks after the PRECHARGE.
- R8: The op field is coded 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE. A valid NOP is always granted. Codes 5 to 7 are never granted. No command is granted while cmd_valid is low.
- R9: A command whose bank number is NUM_BANKS or more is never granted.
- R10: One cycle after a granted command other than NOP, iss_vld is high and iss_op, iss_bank and iss_row carry that command. iss_vld is low in every other cycle.
- R11: After reset all banks are closed and all counters are expired. A READ right after reset is refused, and the first ACTIVATE is granted at once.
- R12: Counters saturate rather than wrap. After a long idle spell, a READ to an open bank and an ACTIVATE to a closed bank are granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A candidate command is present |
| cmd_op | input | 3 | Command code (0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE) |
| cmd_bank | input | BANK_IN_W (4) | Target bank number |
| cmd_row | input | ROW_W (14) | Row address |
| grant | output | 1 | Candidate is legal this cycle and is issued |
| iss_vld | output | 1 | Strobe: a non-NOP command was issued last cycle |
| iss_op | output | 3 | Code of the issued command |
| iss_bank | output | BANK_IN_W (4) | Bank of the issued command |
| iss_row | output | ROW_W (14) | Row of the issued command |

## Verification
Directed sequences come first. They read a bank before and after it is activated, which separates the open-row rule from the activate-to-read delay. They activate an already open bank, and they activate five banks back to back so that the spacing rule and the four-activate window each become the binding limit in turn. They precharge a bank and activate it again at once, which brings out the precharge recovery and the same-bank cycle limits. They also send bad bank numbers and reserved codes, and they idle long enough that an unsaturated counter would wrap. A seeded random stream then mixes all command codes and bank numbers, some of them out of range, with gaps in cmd_valid. A bench model built on absolute issue times predicts the grant in every cycle and the issued strobe one cycle later.

// File: rtl/agt_pkg.sv
package agt_pkg;
    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } agt_op_e;
endpackage

// File: rtl/agt_bank_track.sv
module agt_bank_track #(
    parameter int CW    = 4,
    parameter int T_MAX = 15,
    parameter int T_RCD = 6,
    parameter int T_RC  = 15,
    parameter int T_RP  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_act,
    input  logic ev_pre,
    input  logic ev_rw,
    output logic open_o,
    output logic act_ok_o,
    output logic rw_ok_o
);
    localparam logic [CW-1:0] SAT = CW'(T_MAX);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] since_act;
        logic [CW-1:0] since_pre;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.since_act < SAT) st_d.since_act = st_q.since_act + 1'b1;
        if (st_q.since_pre < SAT) st_d.since_pre = st_q.since_pre + 1'b1;
        if (ev_act) begin
            st_d.open      = 1'b1;
            st_d.since_act = CW'(1);
        end
        if (ev_pre) begin
            st_d.open      = 1'b0;
            st_d.since_pre = CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.open      <= 1'b0;
            st_q.since_act <= SAT;
            st_q.since_pre <= SAT;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o   = st_q.open;
    assign act_ok_o = !st_q.open && (st_q.since_act >= CW'(T_RC))
                      && (st_q.since_pre >= CW'(T_RP));
    assign rw_ok_o  = st_q.open && (st_q.since_act >= CW'(T_RCD));

    AST_RW_NEEDS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rw |-> st_q.open); // R1
    AST_RW_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rw |-> st_q.since_act >= CW'(T_RCD)); // R2
    AST_ACT_ONLY_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        ev_act |-> !st_q.open); // R3
    AST_ACT_AFTER_RC: assert property (@(posedge clk) disable iff (!rst_n)
        ev_act |-> st_q.since_act >= CW'(T_RC)); // R4
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pre |=> !st_q.open); // R7
    AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_act |-> st_q.since_pre >= CW'(T_RP)); // R7
endmodule

// File: rtl/agt_faw_window.sv
module agt_faw_window #(
    parameter int CW     = 4,
    parameter int T_MAX  = 15,
    parameter int T_FAW  = 14,
    parameter int DEPTH  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_act,
    output logic faw_ok_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CW-1:0] SAT  = CW'(T_MAX);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][CW-1:0] age;
        logic [PW-1:0]            oldest;
    } faw_st_t;

    faw_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.age[i] < SAT) st_d.age[i] = st_q.age[i] + 1'b1;
        end
        if (ev_act) begin
            st_d.age[st_q.oldest] = CW'(1);
            st_d.oldest = (st_q.oldest == LAST) ? '0 : st_q.oldest + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) st_q.age[i] <= SAT;
            st_q.oldest <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign faw_ok_o = st_q.age[st_q.oldest] >= CW'(T_FAW);

    AST_FAW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_act |-> st_q.age[st_q.oldest] >= CW'(T_FAW)); // R6
endmodule

// File: rtl/act_timing_guard.sv
module act_timing_guard
    import agt_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BANK_IN_W = 4,
    parameter int ROW_W     = 14,
    parameter int T_RCD     = 6,
    parameter int T_RRD     = 3,
    parameter int T_RC      = 15,
    parameter int T_RP      = 4,
    parameter int T_FAW     = 14,
    parameter int FAW_ACTS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [BANK_IN_W-1:0] cmd_bank,
    input  logic [ROW_W-1:0]     cmd_row,
    output logic                 grant,
    output logic                 iss_vld,
    output logic [2:0]           iss_op,
    output logic [BANK_IN_W-1:0] iss_bank,
    output logic [ROW_W-1:0]     iss_row
);
    localparam int T_M1  = (T_RC > T_RCD) ? T_RC : T_RCD;
    localparam int T_M2  = (T_M1 > T_RRD) ? T_M1 : T_RRD;
    localparam int T_M3  = (T_M2 > T_RP) ? T_M2 : T_RP;
    localparam int T_MAX = (T_M3 > T_FAW) ? T_M3 : T_FAW;
    localparam int CW    = $clog2(T_MAX + 1);
    localparam int BW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam logic [CW-1:0] SAT = CW'(T_MAX);

    typedef struct packed {
        logic [CW-1:0]        since_any_act;
        logic                 vld;
        logic [2:0]           op;
        logic [BANK_IN_W-1:0] bank;
        logic [ROW_W-1:0]     row;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NUM_BANKS-1:0] bank_open, bank_act_ok, bank_rw_ok;
    logic [NUM_BANKS-1:0] ev_act, ev_pre, ev_rw;
    logic                 faw_ok, rrd_ok, in_range, legal, any_act;
    logic [BW-1:0]        idx;

    assign in_range = cmd_bank < BANK_IN_W'(NUM_BANKS);
    assign idx      = cmd_bank[BW-1:0];
    assign rrd_ok   = st_q.since_any_act >= CW'(T_RRD);

    always_comb begin
        legal = 1'b0;
        case (cmd_op)
            3'(OP_NOP): legal = 1'b1;
            3'(OP_ACT): legal = in_range && bank_act_ok[idx] && rrd_ok && faw_ok;
            3'(OP_RD),
            3'(OP_WR):  legal = in_range && bank_rw_ok[idx];
            3'(OP_PRE): legal = in_range;
            default:    legal = 1'b0;
        endcase
    end

    assign grant   = cmd_valid && legal;
    assign any_act = grant && (cmd_op == 3'(OP_ACT));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit       = grant && in_range && (idx == BW'(b));
        assign ev_act[b] = hit && (cmd_op == 3'(OP_ACT));
        assign ev_pre[b] = hit && (cmd_op == 3'(OP_PRE));
        assign ev_rw[b]  = hit && ((cmd_op == 3'(OP_RD)) || (cmd_op == 3'(OP_WR)));

        agt_bank_track #(
            .CW(CW), .T_MAX(T_MAX), .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .ev_act(ev_act[b]), .ev_pre(ev_pre[b]), .ev_rw(ev_rw[b]),
            .open_o(bank_open[b]), .act_ok_o(bank_act_ok[b]), .rw_ok_o(bank_rw_ok[b])
        );
    end

    agt_faw_window #(
        .CW(CW), .T_MAX(T_MAX), .T_FAW(T_FAW), .DEPTH(FAW_ACTS)
    ) u_faw (
        .clk(clk), .rst_n(rst_n), .ev_act(any_act), .faw_ok_o(faw_ok)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.since_any_act < SAT) st_d.since_any_act = st_q.since_any_act + 1'b1;
        if (any_act) st_d.since_any_act = CW'(1);
        st_d.vld  = grant && (cmd_op != 3'(OP_NOP));
        st_d.op   = cmd_op;
        st_d.bank = cmd_bank;
        st_d.row  = cmd_row;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.since_any_act <= SAT;
            st_q.vld           <= 1'b0;
            st_q.op            <= '0;
            st_q.bank          <= '0;
            st_q.row           <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iss_vld  = st_q.vld;
    assign iss_op   = st_q.op;
    assign iss_bank = st_q.bank;
    assign iss_row  = st_q.row;

    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        any_act |-> st_q.since_any_act >= CW'(T_RRD)); // R5
    AST_BAD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !in_range && cmd_op != 3'(OP_NOP)) |-> !grant); // R9
    AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> !grant); // R8
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_act, ev_pre, ev_rw})); // R10
    AST_ISSUE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cmd_op != 3'(OP_NOP)) |=> (iss_vld && iss_op == $past(cmd_op)
            && iss_bank == $past(cmd_bank) && iss_row == $past(cmd_row))); // R10
    AST_NO_STRAY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && cmd_op != 3'(OP_NOP)) |=> !iss_vld); // R10
endmodule

// File: tb/act_timing_guard_bench.sv
module act_timing_guard_bench;
    localparam int NB = 8, BIW = 4, RW = 14;
    localparam int T_RCD = 6, T_RRD = 3, T_RC = 15, T_RP = 4, T_FAW = 14;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [BIW-1:0] cmd_bank = '0;
    logic [RW-1:0] cmd_row = '0;
    logic grant, iss_vld;
    logic [2:0] iss_op;
    logic [BIW-1:0] iss_bank;
    logic [RW-1:0] iss_row;

    int checks = 0, errors = 0;
    int now = 0;
    int t_act[NB], t_pre[NB], hist[4];
    bit open_m[NB];
    int t_any = -1000, hp = 0;
    bit last_grant;

    always #5 clk = ~clk;

    act_timing_guard u_act_timing_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .grant(grant), .iss_vld(iss_vld),
        .iss_op(iss_op), .iss_bank(iss_bank), .iss_row(iss_row)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, now);
        end
    endtask

    function automatic bit model_legal(bit v, int op, int b);
        if (!v) return 1'b0;
        if (op == 0) return 1'b1;
        if (op > 4 || b >= NB) return 1'b0;
        case (op)
            1: return !open_m[b] && (now - t_act[b] >= T_RC) && (now - t_pre[b] >= T_RP)
                      && (now - t_any >= T_RRD) && (now - hist[hp] >= T_FAW);
            2, 3: return open_m[b] && (now - t_act[b] >= T_RCD);
            default: return 1'b1;
        endcase
    endfunction

    function automatic string op_tag(int op, int b);
        if (op > 4) return "R8";
        if (b >= NB && op != 0) return "R9";
        case (op)
            0: return "R8";
            1: return "R5";
            2, 3: return "R2";
            default: return "R7";
        endcase
    endfunction

    task automatic step(input bit v, input int op, input int b, input int row, input string tag);
        bit exp;
        @(negedge clk);
        cmd_valid = v; cmd_op = 3'(op); cmd_bank = BIW'(b); cmd_row = RW'(row);
        #1;
        exp = model_legal(v, op, b);
        check(tag, {31'd0, grant}, {31'd0, exp});
        last_grant = grant;
        @(posedge clk);
        if (exp) begin
            if (op == 1) begin
                open_m[b] = 1'b1; t_act[b] = now; t_any = now;
                hist[hp] = now; hp = (hp + 1) % 4;
            end else if (op == 4) begin
                open_m[b] = 1'b0; t_pre[b] = now;
            end
        end
        now++;
        #1;
        check("R10", {31'd0, iss_vld}, {31'd0, exp && op != 0});
        if (exp && op != 0)
            check("R10", {iss_op, iss_bank, iss_row}, {3'(op), BIW'(b), RW'(row)});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < NB; i++) begin t_act[i] = -1000; t_pre[i] = -1000; open_m[i] = 0; end
        for (int i = 0; i < 4; i++) hist[i] = -1000;
        repeat (3) @(posedge clk);
        #1;
        check("R11", {31'd0, iss_vld}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        step(1, 0, 0, 0, "R8");
        step(0, 0, 0, 0, "R8");
        step(0, 1, 2, 0, "R8");
        step(1, 2, 0, 0, "R11");            // read after reset refused, R1
        step(1, 1, 0, 5, "R11");            // first activate granted at once
        repeat (8) step(1, 2, 0, 0, "R2");  // read walks through T_RCD
        step(1, 3, 0, 0, "R1");
        step(1, 1, 0, 6, "R3");             // bank already open
        for (int b = 1; b <= 5; b++) begin
            for (int k = 0; k < 20; k++) begin
                step(1, 1, b, 100 + b, b == 5 ? "R6" : "R5");
                if (last_grant) break;
            end
        end
        step(1, 4, 1, 0, "R7");
        for (int k = 0; k < 20; k++) begin
            step(1, 1, 1, 7, "R4");
            if (last_grant) break;
        end
        step(1, 4, 2, 0, "R7");
        for (int k = 0; k < 8; k++) begin
            step(1, 1, 2, 8, "R7");
            if (last_grant) break;
        end
        step(1, 1, 9, 0, "R9");
        step(1, 2, 12, 0, "R9");
        step(1, 4, 8, 0, "R9");
        step(1, 6, 0, 0, "R8");
        step(1, 7, 3, 0, "R8");
        repeat (40) step(1, 0, 0, 0, "R12");
        step(1, 2, 0, 0, "R12");
        step(1, 4, 6, 0, "R12");
        repeat (40) step(0, 0, 0, 0, "R12");
        step(1, 1, 6, 9, "R12");

        for (int n = 0; n < 3000; n++) begin
            int r, op, b;
            bit v;
            r = $urandom % 16;
            if (r < 2) op = 0;
            else if (r < 7) op = 1;
            else if (r < 10) op = 2;
            else if (r < 12) op = 3;
            else if (r < 15) op = 4;
            else op = 5 + ($urandom % 3);
            b = ($urandom % 12 < 11) ? ($urandom % 8) : (8 + $urandom % 8);
            v = ($urandom % 10) != 0;
            step(v, op, b, $urandom % 16384, op_tag(op, b));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule